// File: doc/BRIEF.md
# Chip-Enable Write-Protect Gate

This block sits between a processor's active-low memory chip-enable and the memory. While the system is running normally it passes the enable straight through, so the memory sees every access. When the system reset flag rises, the block stops passing new accesses. This keeps a collapsing supply or a resetting processor from writing corrupted data.

An access that is already under way when reset arrives is not cut off. If the enable is low on the cycle reset rises, the gate keeps the memory enabled for a bounded hold window of `HOLD_CYCLES` clock cycles. The window ends early if the processor releases the enable. After the window the gate locks the enable off for the rest of the reset event.

The control is a three-state machine. In `ST_PASS` the output follows the input. `ST_HOLD` extends an in-flight access. In `ST_LOCK` the output is forced inactive. The transitions are:
- PASS to HOLD: reset rises while the enable is low.
- PASS to LOCK: reset rises while the enable is high.
- HOLD to LOCK: the enable goes high or the window runs out.
- HOLD or LOCK to PASS: reset falls.

The block wakes from its own reset in `ST_LOCK`.

Top module: `ce_write_guard`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after `rst_n` rises, `ce_out_n` is 1 whatever `ce_in_n` is.
- R2: In any cycle where `sys_rst` is 0 and was also 0 (with `rst_n` high) in the previous cycle, `ce_out_n` equals `ce_in_n` in that same cycle.
- R3: If `ce_in_n` is 1 in the cycle `sys_rst` rises, `ce_out_n` is 1 for every cycle until `sys_rst` falls, whatever `ce_in_n` does.
- R4: If `ce_in_n` is 0 in the cycle `sys_rst` rises and stays 0, `ce_out_n` is 0 in that entry cycle and in the following `HOLD_CYCLES` cycles, then 1 from the next cycle on.
- R5: During the hold window, `ce_in_n` going to 1 ends the window. `ce_out_n` is 1 in that same cycle and stays 1 even if `ce_in_n` returns to 0.
- R6: Once `ce_out_n` is 1 during a reset event, it stays 1 until `sys_rst` falls.
- R7: `ce_out_n` is never 0 in a cycle where `ce_in_n` is 1.
- R8: After `sys_rst` falls, the gate reopens on the next clock edge. From then on `ce_out_n` follows `ce_in_n`, and the hold timer is cleared, so a later reset event gets a full window again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the gate itself |
| sys_rst | input | 1 | System reset flag, 1 while reset or brownout is asserted |
| ce_in_n | input | 1 | Active-low chip-enable from the processor |
| ce_out_n | output | 1 | Active-low chip-enable to the memory |

## Verification
The gate is driven through directed reset events, each aimed at a different path:
- Reset rises with the enable high, which tests the straight lock-out.
- Reset rises with the enable low and held low, which measures the exact window length in cycles.
- The enable is released partway through the window and then pulled low again, which separates an early end from a timed end.
- Reset is released mid-window and a new event is started, which shows whether the timer is re-armed.

Free toggling of the enable with reset low confirms pass-through. Toggling after the window confirms that the lock ignores the input.

// File: rtl/ce_guard_pkg.sv
`timescale 1ns/1ps
package ce_guard_pkg;
    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_HOLD = 2'd1,
        ST_LOCK = 2'd2
    } guard_state_t;
endpackage

// File: rtl/ce_guard_timer.sv
`timescale 1ns/1ps
module ce_guard_timer #(
    parameter int HOLD_CYCLES = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Counter sits at zero outside the hold state, so every window starts fresh.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (cnt_q != LAST_VAL)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = run && (cnt_q == LAST_VAL);
endmodule

// File: rtl/ce_guard_fsm.sv
`timescale 1ns/1ps
module ce_guard_fsm
    import ce_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sys_rst,
    input  logic         ce_in_n,
    input  logic         hold_last,
    output guard_state_t state_q
);
    guard_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_LOCK;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PASS: begin
                // Only place a reset event can begin: entry is on the rising edge.
                if (sys_rst)
                    state_d = ce_in_n ? ST_LOCK : ST_HOLD;
            end
            ST_HOLD: begin
                if (!sys_rst)
                    state_d = ST_PASS;
                else if (ce_in_n || hold_last)
                    state_d = ST_LOCK;
            end
            ST_LOCK: begin
                if (!sys_rst)
                    state_d = ST_PASS;
            end
            default: state_d = ST_LOCK;
        endcase
    end
endmodule

// File: rtl/ce_guard_outmux.sv
`timescale 1ns/1ps
module ce_guard_outmux
    import ce_guard_pkg::*;
(
    input  guard_state_t state_q,
    input  logic         ce_in_n,
    output logic         ce_out_n
);
    always_comb begin
        unique case (state_q)
            ST_PASS: ce_out_n = ce_in_n;
            ST_HOLD: ce_out_n = ce_in_n;
            ST_LOCK: ce_out_n = 1'b1;
            default: ce_out_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/ce_write_guard.sv
`timescale 1ns/1ps
module ce_write_guard
    import ce_guard_pkg::*;
#(
    parameter int HOLD_CYCLES = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_rst,
    input  logic ce_in_n,
    output logic ce_out_n
);
    guard_state_t state_q;
    logic         hold_run;
    logic         hold_last;

    assign hold_run = (state_q == ST_HOLD);

    ce_guard_timer #(.HOLD_CYCLES(HOLD_CYCLES)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (hold_run),
        .last  (hold_last)
    );

    ce_guard_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_rst   (sys_rst),
        .ce_in_n   (ce_in_n),
        .hold_last (hold_last),
        .state_q   (state_q)
    );

    ce_guard_outmux mux_i (
        .state_q  (state_q),
        .ce_in_n  (ce_in_n),
        .ce_out_n (ce_out_n)
    );
endmodule

// File: rtl/ce_write_guard_chk.sv
`timescale 1ns/1ps
module ce_write_guard_chk #(
    parameter int HOLD_CYCLES = 3000
) (
    input logic clk,
    input logic rst_n,
    input logic sys_rst,
    input logic ce_in_n,
    input logic ce_out_n
);
    localparam int LW = $clog2(HOLD_CYCLES + 3);
    localparam logic [LW-1:0] LMAX = LW'(HOLD_CYCLES + 2);

    // Consecutive earlier cycles with reset asserted and the enable passed low.
    logic [LW-1:0] low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_run_q <= '0;
        else if (sys_rst && !ce_out_n)
            low_run_q <= (low_run_q == LMAX) ? LMAX : low_run_q + 1'b1;
        else
            low_run_q <= '0;
    end

    // R7
    a_r7_low_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_out_n |-> !ce_in_n);

    // R2
    a_r2_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_rst && !$past(sys_rst) && $past(rst_n)) |-> (ce_out_n == ce_in_n));

    // R6 (also covers R3 and the lock after R5)
    a_r6_stay_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && $past(sys_rst) && $past(ce_out_n)) |-> ce_out_n);

    // R4
    a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && !ce_out_n) |-> (low_run_q <= LW'(HOLD_CYCLES)));

    // R3
    a_r3_entry_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && !$past(sys_rst) && $past(rst_n) && ce_in_n) |=> ce_out_n);
endmodule

bind ce_write_guard ce_write_guard_chk #(.HOLD_CYCLES(HOLD_CYCLES)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_rst  (sys_rst),
    .ce_in_n  (ce_in_n),
    .ce_out_n (ce_out_n)
);

// File: tb/ce_write_guard_tb_top.sv
`timescale 1ns/1ps
module ce_write_guard_tb_top;
    localparam int HOLD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_rst = 1'b0;
    logic ce_in_n = 1'b0;
    logic ce_out_n;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    ce_write_guard #(.HOLD_CYCLES(HOLD)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_rst  (sys_rst),
        .ce_in_n  (ce_in_n),
        .ce_out_n (ce_out_n)
    );

    task automatic chk(input string req, input logic exp);
        n_checks++;
        if (ce_out_n !== exp) begin
            n_fails++;
            $display("FAIL %s: ce_out_n=%b expected %b at %0t", req, ce_out_n, exp, $time);
        end
    endtask

    // Drive one cycle's inputs away from the active edge, then sample.
    task automatic step(input logic s, input logic c);
        @(negedge clk);
        sys_rst = s;
        ce_in_n = c;
        #1;
    endtask

    task automatic t_reset();
        step(1'b0, 1'b0);
        chk("R1", 1'b1);
        step(1'b0, 1'b1);
        chk("R1", 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        ce_in_n = 1'b0;
        #1;
        chk("R1", 1'b1);
        step(1'b0, 1'b0);
        chk("R2", 1'b0);
    endtask

    task automatic t_follow();
        logic [7:0] pat = 8'b1011_0010;
        for (int i = 0; i < 8; i++) begin
            step(1'b0, pat[i]);
            chk("R2", pat[i]);
            if (pat[i]) chk("R7", 1'b1);
        end
    endtask

    task automatic t_entry_high();
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        chk("R3", 1'b1);
        for (int i = 0; i < 12; i++) begin
            step(1'b1, i[0]);
            chk("R3", 1'b1);
        end
        step(1'b0, 1'b0);
        chk("R8", 1'b1);
        step(1'b0, 1'b0);
        chk("R8", 1'b0);
    endtask

    task automatic t_full_hold();
        step(1'b0, 1'b0);
        for (int i = 0; i <= HOLD; i++) begin
            step(1'b1, 1'b0);
            chk("R4", 1'b0);
        end
        step(1'b1, 1'b0);
        chk("R4", 1'b1);
        for (int i = 0; i < 6; i++) begin
            step(1'b1, i[0]);
            chk("R6", 1'b1);
        end
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        chk("R8", 1'b0);
    endtask

    task automatic t_early_release();
        step(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b0);
            chk("R4", 1'b0);
        end
        step(1'b1, 1'b1);
        chk("R5", 1'b1);
        for (int i = 0; i < HOLD + 4; i++) begin
            step(1'b1, 1'b0);
            chk("R5", 1'b1);
        end
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        chk("R7", 1'b1);
    endtask

    task automatic t_rearm();
        step(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b0);
            chk("R4", 1'b0);
        end
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        chk("R8", 1'b0);
        for (int i = 0; i <= HOLD; i++) begin
            step(1'b1, 1'b0);
            chk("R8", 1'b0);
        end
        step(1'b1, 1'b0);
        chk("R8", 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        chk("R2", 1'b0);
    endtask

    initial begin
        t_reset();
        t_follow();
        t_entry_high();
        t_full_hold();
        t_early_release();
        t_rearm();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule